// File: doc/BRIEF.md
# T1 Remote Alarm Inserter

This block sits on the transmit side of a T1 framer, where each 193-bit frame is one framing bit followed by 24 eight-bit channel timeslots. The block receives the outgoing serial stream one bit per clock, together with strobes that mark frame starts and multiframe starts. When the remote (yellow) alarm is requested, it rewrites selected bits of the stream. Two multiframe layouts are supported: a 12-frame superframe and a 24-frame extended superframe. For each layout, an encoding-select input chooses between two ways of signalling the alarm.

The block also gates the receive-side serial output towards the system. While the AIS request is high, that output carries all ones.

The alarm request, the encoding select and the layout select are sampled only on the multiframe strobe. A change between two strobes therefore never splits an alarm encoding across a multiframe. Framing generation, alignment and CRC are done elsewhere.

Top module: `t1_remote_alarm_ins`

## Requirements
- R1: While `rst_n` is low, `tx_bit_o` and `rx_bit_o` are 0.
- R2: When no alarm encoding is in force, `tx_bit_o` equals `tx_bit_i` delayed by exactly one clock. No alarm encoding is in force before the first multiframe strobe.
- R3: In the 12-frame layout (`esf_mode_i`=0) with `fmt_sel_i`=0 and the alarm active, bit 2 of every channel timeslot is sent as 0. Bit 2 is the second bit of the timeslot, which is frame position 8k+2 for channel k = 0..23, with position 0 being the framing bit. Every other bit passes unchanged.
- R4: In the 12-frame layout with `fmt_sel_i`=1 and the alarm active, the framing bit of frame 12 is sent as 1. Frames are counted 1 to 12 from the multiframe strobe. Every other bit passes unchanged.
- R5: In the 24-frame layout (`esf_mode_i`=1) with `fmt_sel_i`=0 and the alarm active, the data-link bits carry a repeating pattern of eight 1s followed by eight 0s, one pattern bit per data-link bit. The data-link bits are the framing bits of the odd frames 1, 3, ..., 23. The pattern starts at its first 1 in frame 1 of the first multiframe in which this encoding is in force. Every other bit passes unchanged.
- R6: In the 24-frame layout with `fmt_sel_i`=1 and the alarm active, bit 2 of every channel timeslot is sent as 0. The bit positions are the same as in R3.
- R7: `alarm_en_i`, `fmt_sel_i` and `esf_mode_i` are sampled only in the cycle where `mf_i` is high, and the sampled values apply from that bit on. A change at any other time has no effect on `tx_bit_o` until the next multiframe strobe.
- R8: While the R5 encoding stays in force across multiframe strobes, the pattern continues from where it stopped and does not restart. A multiframe holds 12 data-link bits, which is not a multiple of 16.
- R9: `rx_bit_o` is 1 one clock after any cycle in which `send_ais_i` is high. Otherwise it equals `rx_bit_i` delayed by one clock. No other input affects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one stream bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_bit_i | input | 1 | Outgoing stream bit before alarm insertion |
| frame_i | input | 1 | High on the framing bit of each frame |
| mf_i | input | 1 | High on the framing bit of frame 1 of a multiframe, together with `frame_i` |
| esf_mode_i | input | 1 | Layout select: 0 = 12-frame, 1 = 24-frame, sampled on `mf_i` |
| fmt_sel_i | input | 1 | Alarm encoding select, sampled on `mf_i` |
| alarm_en_i | input | 1 | Remote alarm request, sampled on `mf_i` |
| tx_bit_o | output | 1 | Outgoing stream after insertion, one clock late |
| rx_bit_i | input | 1 | Receive-side bit towards the system |
| send_ais_i | input | 1 | Forces the system-side output to all ones |
| rx_bit_o | output | 1 | System-side output, one clock late |

## Verification
The hardest situation to reach from the ports is the data-link pattern carried across several multiframes, because it is not aligned to the 16-bit pattern period. A second hard case is a settings change that arrives in the middle of a multiframe and must stay invisible until the next strobe. The stimulus holds the 24-frame pattern encoding for more than three full multiframes so that the pattern index wraps at different points. It also changes the encoding select and the alarm request at arbitrary bit positions, including a short excursion that begins and ends between two strobes. A behavioural model counts bit positions and frames independently of the design and predicts every output bit, so each rewritten position and each passed bit is compared.

// File: rtl/t1ra_pkg.sv
// Shared types for the T1 remote alarm inserter.
package t1ra_pkg;

    // Which alarm rewrite is in force for the current bit
    typedef enum logic [1:0] {
        ENC_NONE  = 2'd0,
        ENC_BIT2  = 2'd1,
        ENC_FS12  = 2'd2,
        ENC_DLPAT = 2'd3
    } alarm_enc_e;

    // Map the sampled request, layout and encoding select to one rewrite
    function automatic alarm_enc_e pick_enc(input logic act, input logic esf, input logic alt);
        if (!act)
            return ENC_NONE;
        else if (esf)
            return alt ? ENC_BIT2 : ENC_DLPAT;
        else
            return alt ? ENC_FS12 : ENC_BIT2;
    endfunction

endpackage

// File: rtl/t1ra_position.sv
// Tracks the bit position inside the frame and the frame number inside
// the multiframe for the bit that is present on the input this cycle.
// Assumes: one stream bit per clock, frame_i marks the framing bit and
// mf_i, when high, coincides with frame_i. Between strobes the counters
// run freely and wrap on their own.
module t1ra_position #(
    parameter int FRAME_BITS = 193,
    parameter int CH_BITS    = 8,
    parameter int ALARM_BIT  = 2,
    parameter int F12_FRAMES = 12,
    parameter int ESF_FRAMES = 24,
    parameter int POS_W      = 8,
    parameter int FR_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic             mf_i,
    input  logic             esf_i,
    output logic [POS_W-1:0] cur_pos_o,
    output logic [FR_W-1:0]  cur_fr_o,
    output logic             is_fbit_o,
    output logic             is_alarm_bit_o
);
    logic [POS_W-1:0] pos_q;
    logic [FR_W-1:0]  fr_q;
    logic [FR_W-1:0]  last_fr;

    // Position and frame number of the bit on the input this cycle
    always_comb begin
        cur_pos_o = frame_i ? '0 : pos_q;
        last_fr   = esf_i ? FR_W'(ESF_FRAMES) : FR_W'(F12_FRAMES);
        if (mf_i)
            cur_fr_o = FR_W'(1);
        else if (cur_pos_o == '0)
            cur_fr_o = (fr_q >= last_fr) ? FR_W'(1) : fr_q + FR_W'(1);
        else
            cur_fr_o = fr_q;
        is_fbit_o      = (cur_pos_o == '0);
        is_alarm_bit_o = (cur_pos_o != '0) &&
                         (((cur_pos_o - POS_W'(1)) % POS_W'(CH_BITS)) == POS_W'(ALARM_BIT - 1));
    end

    // Advance the counters to the next bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            fr_q  <= FR_W'(1);
        end else begin
            pos_q <= (cur_pos_o == POS_W'(FRAME_BITS - 1)) ? '0 : cur_pos_o + POS_W'(1);
            fr_q  <= cur_fr_o;
        end
    end

endmodule

// File: rtl/t1ra_ctrl.sv
// Samples the alarm settings on the multiframe strobe and runs the
// 16-bit data-link alarm pattern. Assumes: settings are stable only as
// far as the strobe cycle, and the settings sampled there apply from
// that bit on. The pattern index is held at zero while the pattern
// encoding is not in force. While that encoding stays in force, the
// index keeps running across strobes.
module t1ra_ctrl
    import t1ra_pkg::*;
#(
    parameter int PAT_LEN  = 16,
    parameter int PAT_ONES = 8,
    parameter int IDX_W    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mf_i,
    input  logic       alarm_en_i,
    input  logic       fmt_i,
    input  logic       esf_i,
    input  logic       is_fbit_i,
    input  logic       fr_odd_i,
    output logic       act_o,
    output logic       esf_o,
    output alarm_enc_e enc_o,
    output logic       pat_bit_o,
    output logic       dl_slot_o
);
    logic             act_q, fmt_q, esf_q;
    logic             fmt_eff;
    logic [IDX_W-1:0] idx_q;

    // Settings in force for this bit: fresh on the strobe, held otherwise
    always_comb begin
        act_o     = mf_i ? alarm_en_i : act_q;
        fmt_eff   = mf_i ? fmt_i      : fmt_q;
        esf_o     = mf_i ? esf_i      : esf_q;
        enc_o     = pick_enc(act_o, esf_o, fmt_eff);
        dl_slot_o = is_fbit_i && fr_odd_i && (enc_o == ENC_DLPAT);
        pat_bit_o = (idx_q < IDX_W'(PAT_ONES));
    end

    // Hold the sampled settings between strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            fmt_q <= 1'b0;
            esf_q <= 1'b0;
        end else begin
            act_q <= act_o;
            fmt_q <= fmt_eff;
            esf_q <= esf_o;
        end
    end

    // Step the pattern index once per data-link bit, clear it when unused
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (enc_o != ENC_DLPAT)
            idx_q <= '0;
        else if (dl_slot_o)
            idx_q <= (idx_q == IDX_W'(PAT_LEN - 1)) ? '0 : idx_q + IDX_W'(1);
    end

endmodule

// File: rtl/t1ra_insert.sv
// Applies the selected alarm rewrite to the current stream bit and
// registers the result. Assumes the position flags and the encoding
// all refer to the bit on tx_bit_i in the same cycle.
module t1ra_insert
    import t1ra_pkg::*;
#(
    parameter int FR_W     = 5,
    parameter int FS_FRAME = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_bit_i,
    input  alarm_enc_e      enc_i,
    input  logic            is_fbit_i,
    input  logic            is_alarm_bit_i,
    input  logic [FR_W-1:0] fr_i,
    input  logic            dl_slot_i,
    input  logic            pat_bit_i,
    output logic            tx_bit_o
);
    logic tx_next;

    // Choose the outgoing value of this bit
    always_comb begin
        tx_next = tx_bit_i;
        unique case (enc_i)
            ENC_BIT2:  if (is_alarm_bit_i) tx_next = 1'b0;
            ENC_FS12:  if (is_fbit_i && fr_i == FR_W'(FS_FRAME)) tx_next = 1'b1;
            ENC_DLPAT: if (dl_slot_i) tx_next = pat_bit_i;
            default:   tx_next = tx_bit_i;
        endcase
    end

    // One-clock output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_bit_o <= 1'b0;
        else
            tx_bit_o <= tx_next;
    end

endmodule

// File: rtl/t1ra_ais.sv
// Drives the system-side receive output to all ones while AIS is
// requested. Assumes nothing else may mask the request.
module t1ra_ais (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit_i,
    input  logic send_ais_i,
    output logic rx_bit_o
);
    // Register the gated receive bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_bit_o <= 1'b0;
        else
            rx_bit_o <= send_ais_i ? 1'b1 : rx_bit_i;
    end

endmodule

// File: rtl/t1_remote_alarm_ins.sv
// Top of the T1 remote alarm inserter. The position tracker, the
// settings/pattern control and the bit rewriter run on the transmit
// stream, and the AIS gate runs on the receive-side system output.
// Assumes: one bit per clock on both streams, strobes aligned to the
// framing bit, and the multiframe strobe only together with the frame
// strobe.
module t1_remote_alarm_ins
    import t1ra_pkg::*;
#(
    parameter int CHANNELS   = 24,
    parameter int CH_BITS    = 8,
    parameter int ALARM_BIT  = 2,
    parameter int F12_FRAMES = 12,
    parameter int ESF_FRAMES = 24,
    parameter int PAT_LEN    = 16,
    parameter int PAT_ONES   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_bit_i,
    input  logic frame_i,
    input  logic mf_i,
    input  logic esf_mode_i,
    input  logic fmt_sel_i,
    input  logic alarm_en_i,
    output logic tx_bit_o,
    input  logic rx_bit_i,
    input  logic send_ais_i,
    output logic rx_bit_o
);
    localparam int FRAME_BITS = 1 + CHANNELS * CH_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int FR_W       = $clog2(ESF_FRAMES + 1);
    localparam int IDX_W      = $clog2(PAT_LEN);

    logic [POS_W-1:0] bit_pos;
    logic [FR_W-1:0]  frame_no;
    logic             is_fbit, is_alarm_bit;
    logic             alarm_act, alarm_esf, pat_bit, dl_slot;
    alarm_enc_e       enc;

    t1ra_position #(
        .FRAME_BITS (FRAME_BITS),
        .CH_BITS    (CH_BITS),
        .ALARM_BIT  (ALARM_BIT),
        .F12_FRAMES (F12_FRAMES),
        .ESF_FRAMES (ESF_FRAMES),
        .POS_W      (POS_W),
        .FR_W       (FR_W)
    ) u_pos (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_i        (frame_i),
        .mf_i           (mf_i),
        .esf_i          (alarm_esf),
        .cur_pos_o      (bit_pos),
        .cur_fr_o       (frame_no),
        .is_fbit_o      (is_fbit),
        .is_alarm_bit_o (is_alarm_bit)
    );

    t1ra_ctrl #(
        .PAT_LEN  (PAT_LEN),
        .PAT_ONES (PAT_ONES),
        .IDX_W    (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mf_i       (mf_i),
        .alarm_en_i (alarm_en_i),
        .fmt_i      (fmt_sel_i),
        .esf_i      (esf_mode_i),
        .is_fbit_i  (is_fbit),
        .fr_odd_i   (frame_no[0]),
        .act_o      (alarm_act),
        .esf_o      (alarm_esf),
        .enc_o      (enc),
        .pat_bit_o  (pat_bit),
        .dl_slot_o  (dl_slot)
    );

    t1ra_insert #(
        .FR_W     (FR_W),
        .FS_FRAME (F12_FRAMES)
    ) u_ins (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_bit_i       (tx_bit_i),
        .enc_i          (enc),
        .is_fbit_i      (is_fbit),
        .is_alarm_bit_i (is_alarm_bit),
        .fr_i           (frame_no),
        .dl_slot_i      (dl_slot),
        .pat_bit_i      (pat_bit),
        .tx_bit_o       (tx_bit_o)
    );

    t1ra_ais u_ais (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit_i   (rx_bit_i),
        .send_ais_i (send_ais_i),
        .rx_bit_o   (rx_bit_o)
    );

endmodule

// File: rtl/t1ra_checker.sv
// Temporal checks for the T1 remote alarm inserter, bound to the top.
module t1ra_checker
    import t1ra_pkg::*;
#(
    parameter int FR_W     = 5,
    parameter int FS_FRAME = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mf_i,
    input logic            tx_bit_i,
    input logic            tx_bit_o,
    input logic            rx_bit_i,
    input logic            send_ais_i,
    input logic            rx_bit_o,
    input alarm_enc_e      enc,
    input logic            is_fbit,
    input logic            is_alarm_bit,
    input logic [FR_W-1:0] frame_no,
    input logic            alarm_act
);
    AST_AIS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        send_ais_i |=> rx_bit_o); // R9
    AST_RX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !send_ais_i |=> (rx_bit_o == $past(rx_bit_i))); // R9
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (enc == ENC_NONE) |=> (tx_bit_o == $past(tx_bit_i))); // R2
    AST_BIT2_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enc == ENC_BIT2 && is_alarm_bit) |=> !tx_bit_o); // R3
    AST_FS12_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (enc == ENC_FS12 && is_fbit && frame_no == FR_W'(FS_FRAME)) |=> tx_bit_o); // R4
    AST_SETTING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alarm_act) |-> mf_i); // R7
endmodule

bind t1_remote_alarm_ins t1ra_checker #(
    .FR_W     (FR_W),
    .FS_FRAME (F12_FRAMES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mf_i         (mf_i),
    .tx_bit_i     (tx_bit_i),
    .tx_bit_o     (tx_bit_o),
    .rx_bit_i     (rx_bit_i),
    .send_ais_i   (send_ais_i),
    .rx_bit_o     (rx_bit_o),
    .enc          (enc),
    .is_fbit      (is_fbit),
    .is_alarm_bit (is_alarm_bit),
    .frame_no     (frame_no),
    .alarm_act    (alarm_act)
);

// File: tb/t1_remote_alarm_ins_test.sv
`timescale 1ns/1ps
module t1_remote_alarm_ins_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_bit_i = 1'b0, frame_i = 1'b0, mf_i = 1'b0;
    logic esf_mode_i = 1'b0, fmt_sel_i = 1'b0, alarm_en_i = 1'b0;
    logic rx_bit_i = 1'b0, send_ais_i = 1'b0;
    logic tx_bit_o, rx_bit_o;

    t1_remote_alarm_ins uut (
        .clk(clk), .rst_n(rst_n), .tx_bit_i(tx_bit_i), .frame_i(frame_i),
        .mf_i(mf_i), .esf_mode_i(esf_mode_i), .fmt_sel_i(fmt_sel_i),
        .alarm_en_i(alarm_en_i), .tx_bit_o(tx_bit_o), .rx_bit_i(rx_bit_i),
        .send_ais_i(send_ais_i), .rx_bit_o(rx_bit_o)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit ais_rand = 1'b0;

    // stream generator and behavioural model state
    int    g_pos = 150;
    int    g_fr  = 12;
    bit    m_sync = 0, m_act = 0, m_esf = 0, m_fmt = 0;
    int    m_idx = 0;
    int    m_mfs = 0;
    bit    have_exp = 0;
    bit    exp_tx, exp_rx;
    string tx_tag, rx_tag;

    task automatic check(input string tag, input bit got, input bit expv, input string what);
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at cycle %0d", tag, what, got, expv, cyc);
        end
    endtask

    // one bit per call: compare the previous prediction, then drive and predict
    task automatic step();
        bit tb, rb, fi, mi, e, dlpat_now;
        string tg;
        @(negedge clk);
        cyc++;
        if (have_exp) begin
            check(tx_tag, tx_bit_o, exp_tx, "tx");
            check(rx_tag, rx_bit_o, exp_rx, "rx");
        end
        tb = 1'($urandom);
        rb = 1'($urandom);
        fi = (g_pos == 0);
        mi = fi && (g_fr == 1);
        if (ais_rand) send_ais_i = ($urandom_range(0, 3) == 0);
        tx_bit_i = tb; rx_bit_i = rb; frame_i = fi; mf_i = mi;
        if (mi) begin
            dlpat_now = alarm_en_i && esf_mode_i && !fmt_sel_i;
            if (!(dlpat_now && m_act && m_esf && !m_fmt)) begin
                m_idx = 0;
                m_mfs = 0;
            end else begin
                m_mfs++;
            end
            m_act = alarm_en_i; m_esf = esf_mode_i; m_fmt = fmt_sel_i; m_sync = 1;
        end
        e = tb;
        tg = "R2";
        if (!mi && (alarm_en_i != m_act || fmt_sel_i != m_fmt || esf_mode_i != m_esf))
            tg = "R7";
        if (m_sync && m_act) begin
            if (!m_esf && !m_fmt && g_pos > 0 && ((g_pos - 1) % 8) == 1) begin
                e = 1'b0; tg = "R3";
            end
            if (m_esf && m_fmt && g_pos > 0 && ((g_pos - 1) % 8) == 1) begin
                e = 1'b0; tg = "R6";
            end
            if (!m_esf && m_fmt && g_pos == 0 && g_fr == 12) begin
                e = 1'b1; tg = "R4";
            end
            if (m_esf && !m_fmt && g_pos == 0 && (g_fr % 2) == 1) begin
                e = (m_idx < 8);
                tg = (m_mfs > 0) ? "R8" : "R5";
                m_idx = (m_idx + 1) % 16;
            end
        end
        exp_tx = e;
        tx_tag = tg;
        exp_rx = send_ais_i ? 1'b1 : rb;
        rx_tag = "R9";
        have_exp = 1;
        g_pos++;
        if (g_pos == 193) begin
            g_pos = 0;
            g_fr = (g_fr >= (m_esf ? 24 : 12)) ? 1 : g_fr + 1;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs held low in reset, with inputs high
        tx_bit_i = 1'b1; rx_bit_i = 1'b1; send_ais_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", tx_bit_o, 1'b0, "tx in reset");
        check("R1", rx_bit_o, 1'b0, "rx in reset");
        send_ais_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R9: alarm off, pass-through with AIS toggling
        ais_rand = 1'b1;
        run(3000);
        // R3: 12-frame, bit-2 zeroing, enabled mid-multiframe (R7)
        alarm_en_i = 1'b1; esf_mode_i = 1'b0; fmt_sel_i = 1'b0;
        run(6000);
        // R4: 12-frame, framing bit of frame 12
        fmt_sel_i = 1'b1;
        run(6000);
        // R5, R8: 24-frame data-link pattern over several multiframes
        esf_mode_i = 1'b1; fmt_sel_i = 1'b0;
        run(7000);
        // R7: short excursion of the select that never reaches a strobe
        fmt_sel_i = 1'b1;
        run(400);
        fmt_sel_i = 1'b0;
        run(9000);
        // R6: 24-frame bit-2 zeroing
        fmt_sel_i = 1'b1;
        run(10000);
        // R7: alarm dropped, stays in force until the strobe
        alarm_en_i = 1'b0;
        run(6000);
        // R7: brief request between strobes has no effect
        alarm_en_i = 1'b1; esf_mode_i = 1'b0;
        run(300);
        alarm_en_i = 1'b0;
        run(3000);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule